// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block arbitrates interrupts for a small stack-based processor. It has eight levels with fixed priority: level 7 is the highest and level 0 the lowest. Each level owns one bit in a pending register and one bit in an active register. Hardware request pulses and software-interrupt writes set pending bits. When dispatch is allowed, the controller picks the most urgent pending level and marks it active. It then raises a one-cycle take pulse that carries the level number and the level's vector address.

A level marked active stays active until the core signals a return. The return clears both the pending and the active bit of the highest active level. A pending level may preempt the routine that is running only if its level is above every active level. This lets routines nest several levels deep. While the global enable is low, requests are still recorded in the pending register but no routine is started. A request that arrives for a level whose pending bit is already set is absorbed and lost.

Top module: `irq_nest_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `pend` and `act` are zero and `take` is low.
- R2: A hardware request bit is written into `pend` at a clock edge only if `sample_en` is high at that edge. A request pulse given while `sample_en` is low leaves `pend` unchanged.
- R3: A clock edge with `swi_we` high sets the pending bits marked in `swi_bits`, whatever the value of `sample_en`. The controller then dispatches those levels exactly as it dispatches hardware requests.
- R4: While `glob_en` is low, `take` stays low and new requests still collect in `pend`. At the first edge where `glob_en` is high, the controller dispatches, and `take` is high in the following cycle.
- R5: A dispatch takes the highest pending level that is not active. `take` is high for exactly one cycle. `take_lvl` gives the level, and the level's bit in `act` is set in that same cycle.
- R6: During `take`, `take_vec` holds 0x040 × (level+1) for levels 0 to 6, and 0x1E0 for level 7.
- R7: A pending level is dispatched only if it is above the highest active level. A pending level at or below that level waits until every active level above it has returned.
- R8: A clock edge with `reti` high clears the `pend` and `act` bits of the highest active level, and no dispatch happens at that edge. With no level active, `reti` has no effect.
- R9: A request for a level whose pending bit is already set is lost. This holds also at the edge where that bit is cleared by `reti`. The level is then not serviced a second time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_req | input | 8 | Hardware request pulses, one bit per level |
| sample_en | input | 1 | High in cycles that are not I/O cycles; hardware requests are taken only then |
| swi_we | input | 1 | Software-interrupt write strobe |
| swi_bits | input | 8 | Levels to be set pending by a software write |
| glob_en | input | 1 | Global dispatch enable |
| reti | input | 1 | Return strobe for the routine that is finishing |
| take | output | 1 | One-cycle pulse: start the routine at take_vec |
| take_lvl | output | 3 | Level of the last dispatch |
| take_vec | output | 12 | Vector address of the last dispatch |
| pend | output | 8 | Pending register |
| act | output | 8 | Active register |

## Verification
The bench builds the controller with its default parameters: eight levels, 12-bit vectors, a 0x040 step and 0x1E0 for the top level. With these values the whole vector table can be checked, level by level, through software writes. Nesting can also reach from level 0 up to level 7. A behavioural model runs alongside the design and tracks pending and active state as integer-indexed bits. Directed sequences then cover gated sampling, dispatch held off by the enable, preemption and blocked lower levels, returns with nothing active, and requests lost against a pending bit that is still set.

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl #(
  parameter int LEVELS   = 8,
  parameter int VEC_W    = 12,
  parameter int VEC_STEP = 'h040,
  parameter int TOP_VEC  = 'h1E0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [LEVELS-1:0]         irq_req,
  input  logic                      sample_en,
  input  logic                      swi_we,
  input  logic [LEVELS-1:0]         swi_bits,
  input  logic                      glob_en,
  input  logic                      reti,
  output logic                      take,
  output logic [$clog2(LEVELS)-1:0] take_lvl,
  output logic [VEC_W-1:0]          take_vec,
  output logic [LEVELS-1:0]         pend,
  output logic [LEVELS-1:0]         act
);
  localparam int LW = $clog2(LEVELS);
  localparam logic [LEVELS-1:0] ONE = LEVELS'(1);

  logic [LEVELS-1:0] pend_q, act_q, ready, set_m, clr_m, grant_m;
  logic [LW-1:0]     act_top, cand_top;
  logic              act_any, cand_any, dispatch;

  function automatic logic [VEC_W-1:0] vec_of(input logic [LW-1:0] l);
    if (int'(l) == LEVELS-1) return VEC_W'(TOP_VEC);
    return VEC_W'((int'(l) + 1) * VEC_STEP);
  endfunction

  assign ready = pend_q & ~act_q;

  always_comb begin
    act_any  = 1'b0;
    act_top  = '0;
    cand_any = 1'b0;
    cand_top = '0;
    for (int i = 0; i < LEVELS; i++) begin
      if (act_q[i]) begin
        act_any = 1'b1;
        act_top = LW'(i);
      end
      if (ready[i]) begin
        cand_any = 1'b1;
        cand_top = LW'(i);
      end
    end
  end

  assign dispatch = glob_en && !reti && cand_any && (!act_any || cand_top > act_top);
  assign grant_m  = dispatch ? (ONE << cand_top) : '0;
  assign clr_m    = (reti && act_any) ? (ONE << act_top) : '0;
  assign set_m    = (sample_en ? irq_req : '0) | (swi_we ? swi_bits : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= '0;
      act_q    <= '0;
      take     <= 1'b0;
      take_lvl <= '0;
      take_vec <= '0;
    end else begin
      pend_q <= (pend_q & ~clr_m) | (set_m & ~pend_q);
      act_q  <= (act_q & ~clr_m) | grant_m;
      take   <= dispatch;
      if (dispatch) begin
        take_lvl <= cand_top;
        take_vec <= vec_of(cand_top);
      end
    end
  end

  assign pend = pend_q;
  assign act  = act_q;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (pend_q == '0 && act_q == '0 && !take));

  // R5
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> $countones(act_q) == $countones($past(act_q)) + 1);

  // R4
  gated_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> $past(glob_en));

  // R7
  preempt_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (($past(act_q) >> take_lvl) == '0));

  // R8
  reti_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && act_q != '0) |=> $countones(act_q) == $countones($past(act_q)) - 1);

  // R9
  act_in_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q & ~pend_q) == '0);
endmodule

// File: tb/irq_nest_ctrl_test.sv
module irq_nest_ctrl_test;
  localparam int CLK_NS = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq_req = '0;
  logic       sample_en = 1'b1;
  logic       swi_we = 1'b0;
  logic [7:0] swi_bits = '0;
  logic       glob_en = 1'b0;
  logic       reti = 1'b0;
  logic       take;
  logic [2:0] take_lvl;
  logic [11:0] take_vec;
  logic [7:0] pend, act;

  int errors = 0;
  int checks = 0;
  string cur_req = "R1";

  bit m_pend[8];
  bit m_act[8];
  bit m_take;
  int m_lvl;

  irq_nest_ctrl uut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .sample_en(sample_en),
    .swi_we(swi_we), .swi_bits(swi_bits), .glob_en(glob_en), .reti(reti),
    .take(take), .take_lvl(take_lvl), .take_vec(take_vec), .pend(pend), .act(act)
  );

  always #(CLK_NS/2) clk = ~clk;

  function automatic int vec_tab(int l);
    case (l)
      0: return 'h040; 1: return 'h080; 2: return 'h0C0; 3: return 'h100;
      4: return 'h140; 5: return 'h180; 6: return 'h1C0; default: return 'h1E0;
    endcase
  endfunction

  function automatic int mvec(bit v[8]);
    int r = 0;
    for (int i = 0; i < 8; i++) if (v[i]) r += (1 << i);
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) begin m_pend[i] = 0; m_act[i] = 0; end
      m_take = 0;
    end else begin
      bit old_p[8];
      bit req;
      int top_a;
      int cand;
      old_p = m_pend;
      top_a = -1;
      cand = -1;
      for (int i = 0; i < 8; i++) begin
        if (m_act[i]) top_a = i;
        if (m_pend[i] && !m_act[i]) cand = i;
      end
      m_take = 0;
      if (reti) begin
        if (top_a >= 0) begin m_pend[top_a] = 0; m_act[top_a] = 0; end
      end else if (glob_en && cand > top_a) begin
        m_act[cand] = 1;
        m_take = 1;
        m_lvl = cand;
      end
      for (int i = 0; i < 8; i++) begin
        req = (sample_en && irq_req[i]) || (swi_we && swi_bits[i]);
        if (req && !old_p[i]) m_pend[i] = 1;
      end
    end
  end

  task automatic chk(string req, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, got, exp);
    end
  endtask

  task automatic cmp_model();
    chk(cur_req, "model pend", int'(pend), mvec(m_pend));
    chk(cur_req, "model act", int'(act), mvec(m_act));
    chk(cur_req, "model take", int'(take), int'(m_take));
    if (m_take) begin
      chk(cur_req, "model level", int'(take_lvl), m_lvl);
      chk(cur_req, "model vector", int'(take_vec), vec_tab(m_lvl));
    end
  endtask

  task automatic cyc(int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      #1;
      cmp_model();
    end
  endtask

  task automatic hw(logic [7:0] b);
    irq_req = b; cyc(); irq_req = '0;
  endtask

  task automatic ret();
    reti = 1'b1; cyc(); reti = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "pend in reset", int'(pend), 0);
    chk("R1", "act in reset", int'(act), 0);
    rst_n = 1'b1;
    cyc();
    chk("R1", "take after reset", int'(take), 0);

    cur_req = "R2";
    sample_en = 1'b0;
    hw(8'h04);
    chk("R2", "unsampled request", int'(pend), 0);
    sample_en = 1'b1;
    hw(8'h04);
    chk("R2", "sampled request", int'(pend), 'h04);

    cur_req = "R4";
    cyc(3);
    chk("R4", "no take while disabled", int'(take), 0);
    glob_en = 1'b1;
    cyc();
    chk("R4", "take after enable", int'(take), 1);
    chk("R4", "level after enable", int'(take_lvl), 2);
    cyc();
    chk("R5", "take one cycle", int'(take), 0);
    cur_req = "R8";
    ret();
    chk("R8", "pend after return", int'(pend), 0);
    chk("R8", "act after return", int'(act), 0);

    cur_req = "R5";
    glob_en = 1'b0;
    hw(8'h29);
    glob_en = 1'b1;
    cyc();
    chk("R5", "highest first", int'(take_lvl), 5);
    cyc();
    chk("R7", "lower blocked", int'(take), 0);
    ret();
    chk("R8", "no dispatch on return", int'(take), 0);
    chk("R8", "level 5 cleared", int'(pend), 'h09);
    cyc();
    chk("R5", "next level", int'(take_lvl), 3);
    ret();
    cyc();
    chk("R5", "last level", int'(take_lvl), 0);
    ret();

    cur_req = "R7";
    hw(8'h02);
    cyc();
    chk("R7", "base routine", int'(act), 'h02);
    hw(8'h40);
    cyc();
    chk("R7", "preempt level", int'(take_lvl), 6);
    chk("R7", "nested act", int'(act), 'h42);
    hw(8'h10);
    cyc();
    chk("R7", "mid level waits", int'(take), 0);
    chk("R7", "mid level pending", int'(pend), 'h52);
    ret();
    cyc();
    chk("R7", "mid level after return", int'(take_lvl), 4);
    chk("R7", "act after mid dispatch", int'(act), 'h12);
    ret();
    ret();
    chk("R8", "nest unwound", int'(act), 0);

    cur_req = "R3";
    sample_en = 1'b0;
    for (int l = 7; l >= 0; l--) begin
      swi_bits = 8'(1 << l); swi_we = 1'b1; cyc(); swi_we = 1'b0;
      chk("R3", "software write", int'(pend), 1 << l);
      cyc();
      chk("R6", "vector", int'(take_vec), vec_tab(l));
      chk("R3", "software dispatch", int'(take_lvl), l);
      ret();
    end
    sample_en = 1'b1;

    cur_req = "R9";
    glob_en = 1'b0;
    hw(8'h08);
    hw(8'h08);
    glob_en = 1'b1;
    cyc();
    chk("R9", "single dispatch", int'(take_lvl), 3);
    hw(8'h08);
    irq_req = 8'h08; reti = 1'b1; cyc(); irq_req = '0; reti = 1'b0;
    chk("R9", "lost on return edge", int'(pend), 0);
    cyc(3);
    chk("R9", "no second service", int'(act), 0);

    cur_req = "R8";
    glob_en = 1'b0;
    hw(8'h02);
    ret();
    chk("R8", "return with none active", int'(pend), 'h02);
    glob_en = 1'b1;
    cyc(2);
    ret();
    cyc(2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule